// File: doc/BRIEF.md
# Extended Arithmetic Occupancy Controller

This block is the issue control for a shared extended arithmetic unit that performs multiplies, single-width divides, double-width divides and 64-bit shifts. A requester presents an operation code on a valid/ready request channel. The controller grants an operation only when the unit is free. It then holds the unit busy for that operation's occupancy time, using a down-counter that stands in for the arithmetic datapath.

Reading the unit's result register also contends for the unit, so a read waits while an operation is in flight. Writing operands into the unit never waits. When a multiply or divide finishes, the controller raises a one-cycle result-ready pulse. After a result read it flags a one-cycle address hazard: a value read from the unit and then used as a memory address needs an effective latency of two cycles.

Back-pressure rules: a transfer happens in a cycle where `req_valid` and `req_ready` are both high, and `issue_grant` marks that cycle. While `req_ready` is low, the requester must hold `req_valid` and `req_op` steady. No request is ever dropped. `req_ready` depends only on `req_op` and the unit's occupancy, never on `req_valid`.

Top module: `eam_occ_ctrl`

## Requirements
- R1: After reset, `busy`, `result_ready` and `addr_hazard` are low, and `req_ready` is high for every code.
- R2: Operand write (code 0) is ready in every cycle, including while busy. It leaves `busy` and the timing of any pending result unchanged.
- R3: A 64-bit shift (code 1) issued to an idle unit occupies it only in its grant cycle: `busy` stays low afterwards and no result pulse follows.
- R4: A multiply (code 2) keeps `busy` high for the 2 cycles after its grant, and `result_ready` rises 3 cycles after the grant.
- R5: A single-width divide (code 3) keeps `busy` high for the 33 cycles after its grant, and `result_ready` rises 34 cycles after the grant.
- R6: A double-width divide (code 4) keeps `busy` high for the 65 cycles after its grant, and `result_ready` rises 66 cycles after the grant.
- R7: Codes 1 to 5 see `req_ready` low while `busy` is high. A held request of these codes is granted in the first cycle in which `busy` is low.
- R8: A result read (code 5) is granted only when the unit is idle, and it does not raise `busy`.
- R9: `addr_hazard` is high in the cycle after a result-read grant, and low again in the cycle after that if no further read is granted.
- R10: `result_ready` is a single-cycle pulse that follows only multiplies and divides.
- R11: Reserved codes 6 and 7 are accepted at once, even while busy, and have no effect on `busy` or `result_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Operation code (0 write, 1 shift, 2 mul, 3 div, 4 double div, 5 result read, 6/7 reserved) |
| req_ready | output | 1 | Controller can take the presented code this cycle |
| issue_grant | output | 1 | Request transferred this cycle |
| busy | output | 1 | Unit occupied by an earlier operation |
| result_ready | output | 1 | Multiply/divide result available this cycle |
| addr_hazard | output | 1 | Value just read from the unit is not yet safe as an address |

## Verification
A counter that is loaded wrongly or stuck shows up on `busy` in the cycle after the grant. It also shows up on `result_ready` at the exact cycle count of 3, 34 or 66, so latency is measured edge by edge rather than bounded. A lost pending flag suppresses the result pulse, and a stale one repeats it one cycle later. A wrong contention decision is visible at once on `req_ready`: the wait of a held request is counted, and so is the absence of any wait for writes and reserved codes.

// File: rtl/eam_occ_pkg.sv
package eam_occ_pkg;

  typedef enum logic [2:0] {
    EOP_WROP  = 3'd0,
    EOP_SHIFT = 3'd1,
    EOP_MUL   = 3'd2,
    EOP_DIV   = 3'd3,
    EOP_DIVD  = 3'd4,
    EOP_RDRES = 3'd5,
    EOP_RSV6  = 3'd6,
    EOP_RSV7  = 3'd7
  } eam_op_e;

  // Operations that need the arithmetic unit itself.
  function automatic logic op_contends(input logic [2:0] op);
    return (op >= 3'(EOP_SHIFT)) && (op <= 3'(EOP_RDRES));
  endfunction

  // Operations that end with a result pulse.
  function automatic logic op_has_result(input logic [2:0] op);
    return (op == 3'(EOP_MUL)) || (op == 3'(EOP_DIV)) || (op == 3'(EOP_DIVD));
  endfunction

endpackage

// File: rtl/eam_issue_gate.sv
module eam_issue_gate
  import eam_occ_pkg::*;
#(
  parameter int OP_W = 3
) (
  input  logic            req_valid,
  input  logic [OP_W-1:0] req_op,
  input  logic            unit_idle,
  output logic            req_ready,
  output logic            grant,
  output logic            grant_contend,
  output logic            grant_read
);

  logic contends;

  always_comb begin
    contends      = op_contends(3'(req_op));
    req_ready     = !contends || unit_idle;
    grant         = req_valid && req_ready;
    grant_contend = grant && contends;
    grant_read    = grant && (3'(req_op) == 3'(EOP_RDRES));
  end

endmodule

// File: rtl/eam_occ_timer.sv
module eam_occ_timer
  import eam_occ_pkg::*;
#(
  parameter int OP_W      = 3,
  parameter int OCC_SHIFT = 1,
  parameter int OCC_MUL   = 3,
  parameter int OCC_DIV   = 34,
  parameter int OCC_DIVD  = 66,
  parameter int CNT_W     = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [OP_W-1:0] load_op,
  output logic            busy,
  output logic            idle,
  output logic            result_ready
);

  localparam int NUM_OCC = 4;
  localparam int OCC_TAB [NUM_OCC] = '{OCC_SHIFT, OCC_MUL, OCC_DIV, OCC_DIVD};

  logic [CNT_W-1:0] load_tab [NUM_OCC];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;
  logic             pend_q;

  // Remaining-cycle values per occupying operation, one lane per entry.
  for (genvar g = 0; g < NUM_OCC; g++) begin : g_occ
    assign load_tab[g] = CNT_W'(OCC_TAB[g] - 1);
  end

  always_comb begin
    unique case (3'(load_op))
      3'(EOP_SHIFT): load_val = load_tab[0];
      3'(EOP_MUL):   load_val = load_tab[1];
      3'(EOP_DIV):   load_val = load_tab[2];
      3'(EOP_DIVD):  load_val = load_tab[3];
      default:       load_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= load_val;
      pend_q <= op_has_result(3'(load_op));
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      else             pend_q <= 1'b0;
    end
  end

  assign busy         = (cnt_q != '0);
  assign idle         = (cnt_q == '0);
  assign result_ready = pend_q && (cnt_q == '0);

endmodule

// File: rtl/eam_addr_shadow.sv
module eam_addr_shadow #(
  parameter int HAZ_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic read_grant,
  output logic addr_hazard
);

  logic [HAZ_CYC-1:0] sh_q;

  for (genvar g = 0; g < HAZ_CYC; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) sh_q[g] <= 1'b0;
      else if (g == 0) sh_q[g] <= read_grant;
      else sh_q[g] <= sh_q[(g == 0) ? 0 : g-1];
    end
  end

  assign addr_hazard = |sh_q;

endmodule

// File: rtl/eam_occ_ctrl.sv
module eam_occ_ctrl #(
  parameter int OCC_SHIFT = 1,
  parameter int OCC_MUL   = 3,
  parameter int OCC_DIV   = 34,
  parameter int OCC_DIVD  = 66,
  parameter int ADDR_LAT  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] req_op,
  output logic       req_ready,
  output logic       issue_grant,
  output logic       busy,
  output logic       result_ready,
  output logic       addr_hazard
);

  localparam int OP_W    = 3;
  localparam int OCC_MAX = (OCC_DIVD > OCC_DIV) ? OCC_DIVD : OCC_DIV;
  localparam int CNT_W   = (OCC_MAX > 2) ? $clog2(OCC_MAX) : 1;
  localparam int HAZ_CYC = (ADDR_LAT > 1) ? ADDR_LAT - 1 : 1;

  logic unit_idle;
  logic grant_contend;
  logic grant_read;

  eam_issue_gate #(.OP_W(OP_W)) u_gate (
    .req_valid    (req_valid),
    .req_op       (req_op),
    .unit_idle    (unit_idle),
    .req_ready    (req_ready),
    .grant        (issue_grant),
    .grant_contend(grant_contend),
    .grant_read   (grant_read)
  );

  eam_occ_timer #(
    .OP_W(OP_W), .OCC_SHIFT(OCC_SHIFT), .OCC_MUL(OCC_MUL),
    .OCC_DIV(OCC_DIV), .OCC_DIVD(OCC_DIVD), .CNT_W(CNT_W)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (grant_contend),
    .load_op     (req_op),
    .busy        (busy),
    .idle        (unit_idle),
    .result_ready(result_ready)
  );

  eam_addr_shadow #(.HAZ_CYC(HAZ_CYC)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .read_grant (grant_read),
    .addr_hazard(addr_hazard)
  );

endmodule

// File: rtl/eam_occ_chk.sv
module eam_occ_chk #(
  parameter int OCC_MUL  = 3,
  parameter int OCC_DIV  = 34,
  parameter int OCC_DIVD = 66
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_op,
  input logic       req_ready,
  input logic       issue_grant,
  input logic       busy,
  input logic       result_ready,
  input logic       addr_hazard
);

  logic       contend;
  logic       trk_q;
  logic [7:0] el_q;
  logic [7:0] exp_q;

  assign contend = (req_op >= 3'd1) && (req_op <= 3'd5);

  // Elapsed cycles since the last multiply/divide grant.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trk_q <= 1'b0;
      el_q  <= '0;
      exp_q <= '0;
    end else if (issue_grant && (req_op == 3'd2 || req_op == 3'd3 || req_op == 3'd4)) begin
      trk_q <= 1'b1;
      el_q  <= 8'd1;
      exp_q <= (req_op == 3'd2) ? 8'(OCC_MUL) : (req_op == 3'd3) ? 8'(OCC_DIV) : 8'(OCC_DIVD);
    end else if (trk_q) begin
      if (result_ready) trk_q <= 1'b0;
      el_q <= el_q + 8'd1;
    end
  end

  p_wr_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_op == 3'd0) |-> req_ready);

  p_shift_brief_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_grant && req_op == 3'd1) |=> !busy);

  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    result_ready |-> (trk_q && el_q == exp_q));

  p_block_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && contend) |-> !req_ready);

  p_free_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |-> issue_grant);

  p_rd_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_grant && req_op == 3'd5) |=> (!busy && addr_hazard));

  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    result_ready |=> !result_ready);

  p_rsv_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_op == 3'd6 || req_op == 3'd7) |-> req_ready);

endmodule

bind eam_occ_ctrl eam_occ_chk #(
  .OCC_MUL(OCC_MUL), .OCC_DIV(OCC_DIV), .OCC_DIVD(OCC_DIVD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_ready(req_ready), .issue_grant(issue_grant), .busy(busy),
  .result_ready(result_ready), .addr_hazard(addr_hazard)
);

// File: tb/sim_eam_occ_ctrl.sv
`timescale 1ns/1ps
module sim_eam_occ_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic       req_ready, issue_grant, busy, result_ready, addr_hazard;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  eam_occ_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_ready(req_ready), .issue_grant(issue_grant), .busy(busy),
    .result_ready(result_ready), .addr_hazard(addr_hazard)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Present op and hold it until accepted; returns cycles spent waiting.
  task automatic send(input logic [2:0] op, output int waited);
    waited = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    #1;
    while (!req_ready && waited < 500) begin
      waited++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic next();
    @(negedge clk);
    req_valid = 1'b0;
    req_op    = 3'd0;
    #1;
  endtask

  // After a grant: count cycles to the result pulse and busy cycles seen.
  task automatic measure(output int lat, output int bcnt);
    lat = 0; bcnt = 0;
    do begin
      next();
      lat++;
      if (busy) bcnt++;
    end while (!result_ready && lat < 200);
  endtask

  task automatic t_reset();
    chk(!busy, "R1 busy", busy, 0);
    chk(!result_ready, "R1 result_ready", result_ready, 0);
    chk(!addr_hazard, "R1 addr_hazard", addr_hazard, 0);
    for (int k = 0; k < 8; k++) begin
      req_op = 3'(k); #1;
      chk(req_ready, "R1 ready", req_ready, 1);
    end
    req_op = 3'd0;
  endtask

  task automatic t_shift();
    int w;
    send(3'd1, w);
    chk(w == 0, "R3 shift wait", w, 0);
    next();
    chk(!busy, "R3 busy after shift", busy, 0);
    chk(!result_ready, "R10 no pulse after shift", result_ready, 0);
    send(3'd1, w);
    chk(w == 0, "R3 back-to-back shift", w, 0);
    next(); next();
    chk(!result_ready && !busy, "R10 shift quiet", result_ready, 0);
  endtask

  task automatic t_occ(input logic [2:0] op, input int lat_e, input string tag);
    int w, lat, b;
    send(op, w);
    chk(w == 0, {tag, " idle grant"}, w, 0);
    measure(lat, b);
    chk(lat == lat_e, {tag, " latency"}, lat, lat_e);
    chk(b == lat_e - 1, {tag, " busy cycles"}, b, lat_e - 1);
    next();
    chk(!result_ready, "R10 single pulse", result_ready, 0);
  endtask

  task automatic t_contend();
    int w, lat, b;
    send(3'd2, w);
    send(3'd3, w);
    chk(w == 2, "R7 div held behind mul", w, 2);
    chk(result_ready, "R7 granted in pulse cycle", result_ready, 1);
    measure(lat, b);
    chk(lat == 34, "R7 held div latency", lat, 34);
    next();
  endtask

  task automatic t_write_busy();
    int w, lat, b, w2;
    send(3'd3, w);
    next(); next();
    send(3'd0, w2);
    chk(w2 == 0, "R2 write while busy", w2, 0);
    chk(busy, "R2 busy kept", busy, 1);
    lat = 3;
    do begin next(); lat++; end while (!result_ready && lat < 200);
    chk(lat == 34, "R2 div timing kept", lat, 34);
    next();
  endtask

  task automatic t_read();
    int w;
    send(3'd5, w);
    chk(w == 0, "R8 read idle", w, 0);
    next();
    chk(addr_hazard, "R9 hazard after read", addr_hazard, 1);
    chk(!busy, "R8 read not busy", busy, 0);
    next();
    chk(!addr_hazard, "R9 hazard clears", addr_hazard, 0);
    send(3'd2, w);
    send(3'd5, w);
    chk(w == 2, "R8 read waits for mul", w, 2);
    next();
    chk(addr_hazard, "R9 hazard after held read", addr_hazard, 1);
    next();
  endtask

  task automatic t_rsv();
    int w;
    send(3'd4, w);
    next();
    send(3'd6, w);
    chk(w == 0, "R11 code 6 while busy", w, 0);
    send(3'd7, w);
    chk(w == 0, "R11 code 7 while busy", w, 0);
    chk(busy && !result_ready, "R11 no effect", busy, 1);
    next();
    while (!result_ready && n_chk < 100000) next();
    next();
    send(3'd6, w);
    next();
    chk(!busy && !result_ready, "R11 idle no effect", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_shift();
    t_occ(3'd2, 3,  "R4 mul");
    t_occ(3'd3, 34, "R5 div");
    t_occ(3'd4, 66, "R6 divd");
    t_contend();
    t_write_busy();
    t_read();
    t_rsv();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule